// File: doc/BRIEF.md
# Shared-Bus Multi-Cycle Word Memory

This block is a synchronous, word-addressed store of 4096 twelve-bit words. It has a single bidirectional data bus: write data arrives on it and read data leaves on it. Two strobes choose the operation. A read happens when only the read strobe is high, and a write happens when only the write strobe is high. When the strobes are both high or both low, the memory does not drive the bus and nothing happens. All activity takes place on the rising clock edge.

Each access lasts a fixed number of edges, set by two parameters. The default is two edges for a read and two for a write, and setting the read latency to one builds the faster variant. The first edge of an access captures the address and the operation. A one-cycle done flag marks the cycle after the last edge. A read result stays on the bus for as long as the read strobe is held. A synchronous reset makes every word read as zero and stops any access in progress.

A separate output gives the state of the bus driver enable, so the surrounding chip can see when this block owns the shared bus.

Top module: `sbmem_top`

## Requirements
- R1: After a synchronous reset, every word reads as 0x000, done is low and the memory does not drive the bus.
- R2: A write (write strobe 1, read strobe 0) stores the bus value present on the final edge of the access into the address captured on its first edge.
- R3: A read (read strobe 1, write strobe 0) puts the stored word on the bus in the cycle after its final edge. The word stays on the bus while the read strobe remains high and the write strobe remains low.
- R4: When both strobes are low, or both are high, the memory never drives the bus and no stored word changes.
- R5: Done is high for exactly one cycle. That cycle follows edge RD_LAT of a read, or edge WR_LAT of a write, counting the first edge as 1. Done stays low in the cycles before it.
- R6: Changing the address input after the first edge of an access does not change the word that the access reads or writes.
- R7: If the strobes stop matching the captured operation before the final edge, the access is abandoned. No word is written and done does not rise.
- R8: During a read, the memory does not drive the bus before the final edge.
- R9: Reset stops an access in progress. That access writes nothing and raises no done.
- R10: If the write strobe is still high on the edge after a write completes, that edge starts a new write with the address then present. Its done follows WR_LAT edges later.
- R11: The read driver lets go of the bus in the same cycle that the read strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 12 | Word address, captured on the first edge of an access |
| bus_io | inout | 12 | Shared data bus |
| done_o | output | 1 | One-cycle completion flag |
| bus_drive_o | output | 1 | High while the memory drives bus_io |

## Verification
The hardest case to reach from the ports is an access that is abandoned in the middle. The strobes have to change between the first edge and the final edge while the address is still held inside the block, and the outcome can only be seen through a later read. The stimulus drops the strobe in the cycle after the first edge and then reads the same word back to show it was not changed. It also asserts reset in that same cycle on another write, then reads back both that word and a word written earlier to show reset cleared them. The bench changes the address after the first edge of every access in the table, which proves that the captured address was the one used.

// File: rtl/sbmem_pkg.sv
package sbmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_COMP = 2'd2
    } seq_state_e;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

endpackage

// File: rtl/sbmem_seq.sv
module sbmem_seq
    import sbmem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic              wr_en_o,
    output logic              cap_en_o,
    output logic              done_o,
    output logic              drive_o
);

    localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        seq_state_e        state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
    } seq_t;

    function automatic logic [CNT_W-1:0] lat_of(input op_e o);
        return (o == OP_WR) ? CNT_W'(WR_LAT) : CNT_W'(RD_LAT);
    endfunction

    seq_t cur_q, cur_d;
    logic rd_req, wr_req, try_start, match;
    op_e  new_op;

    assign rd_req = rd_i && !wr_i;
    assign wr_req = wr_i && !rd_i;
    assign new_op = wr_req ? OP_WR : OP_RD;
    assign match  = (cur_q.op == OP_WR) ? wr_req : rd_req;

    always_comb begin
        cur_d      = cur_q;
        cur_d.done = 1'b0;
        wr_en_o    = 1'b0;
        cap_en_o   = 1'b0;
        tgt_addr_o = cur_q.addr;
        try_start  = 1'b0;

        unique case (cur_q.state)
            ST_IDLE: try_start = 1'b1;
            ST_BUSY: begin
                if (!match) begin
                    cur_d.state = ST_IDLE;
                    cur_d.cnt   = '0;
                end else if (cur_q.cnt == lat_of(cur_q.op) - CNT_W'(1)) begin
                    cur_d.state = ST_COMP;
                    cur_d.done  = 1'b1;
                    cur_d.cnt   = '0;
                    wr_en_o     = (cur_q.op == OP_WR);
                    cap_en_o    = (cur_q.op == OP_RD);
                end else begin
                    cur_d.cnt = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_COMP: begin
                if (!(cur_q.op == OP_RD && rd_req)) begin
                    try_start = 1'b1;
                end
            end
            default: cur_d.state = ST_IDLE;
        endcase

        if (try_start) begin
            cur_d.state = ST_IDLE;
            cur_d.cnt   = '0;
            if (rd_req || wr_req) begin
                cur_d.op   = new_op;
                cur_d.addr = addr_i;
                tgt_addr_o = addr_i;
                if (lat_of(new_op) == CNT_W'(1)) begin
                    cur_d.state = ST_COMP;
                    cur_d.done  = 1'b1;
                    wr_en_o     = wr_req;
                    cap_en_o    = rd_req;
                end else begin
                    cur_d.state = ST_BUSY;
                    cur_d.cnt   = CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{state: ST_IDLE, op: OP_RD, addr: '0, cnt: '0, done: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign done_o  = cur_q.done;
    assign drive_o = (cur_q.state == ST_COMP) && (cur_q.op == OP_RD) && rd_req;

    // R7: a mismatch while busy never leads to completion
    p_abort_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_q.state == ST_BUSY && !match) |=> !done_o);

    // R2: every committed write is followed by its done flag
    p_commit_then_done_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> done_o);

    // R5: done lasts one cycle when no access can finish in a single edge
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && RD_LAT > 1 && WR_LAT > 1) |=> !done_o);

    // R9: the edge after reset leaves the sequencer quiet
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!done_o && !drive_o));

endmodule

// File: rtl/sbmem_array.sv
module sbmem_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  valid_q, valid_d;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        valid_d = valid_q;
        if (we_i) begin
            valid_d[addr_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && !rst) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = valid_q[addr_i] ? mem_q[addr_i] : '0;

    // R2: a written word reads back its data on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));

endmodule

// File: rtl/sbmem_top.sv
module sbmem_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 12,
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    inout  wire  [DATA_W-1:0] bus_io,
    output logic              done_o,
    output logic              bus_drive_o
);

    logic [ADDR_W-1:0] tgt_addr;
    logic              wr_en, cap_en, drive;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    sbmem_seq #(
        .ADDR_W(ADDR_W),
        .RD_LAT(RD_LAT),
        .WR_LAT(WR_LAT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .tgt_addr_o(tgt_addr),
        .wr_en_o   (wr_en),
        .cap_en_o  (cap_en),
        .done_o    (done_o),
        .drive_o   (drive)
    );

    sbmem_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .we_i   (wr_en),
        .addr_i (tgt_addr),
        .wdata_i(bus_io),
        .rdata_o(arr_rd)
    );

    always_comb begin
        rdata_d = cap_en ? arr_rd : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_io      = drive ? rdata_q : {DATA_W{1'bz}};
    assign bus_drive_o = drive;

    // R4: the driver is only ever on for a clean read request
    p_drive_clean_read_r4: assert property (@(posedge clk) disable iff (rst)
        bus_drive_o |-> (rd_i && !wr_i));

    // R8: the driver first turns on together with the done flag
    p_drive_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drive_o) |-> done_o);

endmodule

// File: tb/sbmem_top_bench.sv
module sbmem_top_bench;

    localparam int AW  = 12;
    localparam int DW  = 12;
    localparam int RDL = 2;
    localparam int WRL = 2;
    localparam int NV  = 9;

    // {is_write, addr, data}; a read expects data
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 12'h000, 12'h0A5},
        {1'b1, 12'hFFF, 12'h5A3},
        {1'b1, 12'h7FF, 12'h123},
        {1'b0, 12'h000, 12'h0A5},
        {1'b0, 12'hFFF, 12'h5A3},
        {1'b1, 12'h000, 12'hFFF},
        {1'b0, 12'h000, 12'hFFF},
        {1'b0, 12'h7FF, 12'h123},
        {1'b0, 12'h001, 12'h000}
    };

    logic          clk = 1'b0;
    logic          rst, rd, wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] tb_val;
    logic          tb_en;
    wire  [DW-1:0] bus;
    logic          done, drv;
    int            n_chk = 0;
    int            n_bad = 0;

    assign bus = tb_en ? tb_val : {DW{1'bz}};

    always #4 clk = ~clk;

    sbmem_top #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(RDL), .WR_LAT(WRL)) u_sbmem_top (
        .clk(clk), .rst(rst), .rd_i(rd), .wr_i(wr), .addr_i(addr),
        .bus_io(bus), .done_o(done), .bus_drive_o(drv)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr = 1'b1; rd = 1'b0; addr = a; tb_val = d; tb_en = 1'b1;
        for (int i = 1; i < WRL; i++) begin
            @(negedge clk);
            addr = ~a;  // R6: address moves after the first edge
            check(done == 1'b0, "R5 write early done", done, 0);
            check(drv == 1'b0, "R4 no drive on write", drv, 0);
        end
        @(negedge clk);
        check(done == 1'b1, "R5 write done", done, 1);
        wr = 1'b0; tb_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
        @(negedge clk);
        rd = 1'b1; wr = 1'b0; addr = a; tb_en = 1'b0;
        for (int i = 1; i < RDL; i++) begin
            @(negedge clk);
            addr = ~a;  // R6
            check(drv == 1'b0, "R8 no early drive", drv, 0);
            check(done == 1'b0, "R5 read early done", done, 0);
        end
        @(negedge clk);
        check(done == 1'b1, "R5 read done", done, 1);
        check(drv == 1'b1 && bus == e, "R3 R6 read data", bus, e);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
        check(drv == 1'b1 && bus == e, "R3 data held", bus, e);
        rd = 1'b0;
        #1;
        check(drv == 1'b0, "R11 release", drv, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; tb_val = '0; tb_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(drv == 1'b0, "R1 no drive after reset", drv, 0);
        do_read(12'h0A0, 12'h000);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][24]) do_write(VEC[v][23:12], VEC[v][11:0]);  // R2
            else            do_read(VEC[v][23:12], VEC[v][11:0]);   // R3
        end

        // R7: abandoned write and abandoned read
        @(negedge clk);
        wr = 1'b1; addr = 12'h020; tb_val = 12'hBAD; tb_en = 1'b1;
        @(negedge clk);
        wr = 1'b0; tb_en = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 aborted write no done", done, 0);
        @(negedge clk);
        check(done == 1'b0, "R7 aborted write quiet", done, 0);
        do_read(12'h020, 12'h000);
        @(negedge clk);
        rd = 1'b1; addr = 12'hFFF;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && drv == 1'b0, "R7 aborted read", done, 0);

        // R4: both strobes high, then both low
        do_write(12'h030, 12'h333);
        @(negedge clk);
        rd = 1'b1; wr = 1'b1; addr = 12'h030; tb_val = 12'h777; tb_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(drv == 1'b0 && done == 1'b0, "R4 both high", drv, 0);
        end
        rd = 1'b0; wr = 1'b0; tb_en = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(drv == 1'b0 && done == 1'b0, "R4 both low", done, 0);
        end
        do_read(12'h030, 12'h333);

        // R10: back-to-back writes with the strobe held
        @(negedge clk);
        wr = 1'b1; addr = 12'h100; tb_val = 12'hAAA; tb_en = 1'b1;
        repeat (WRL) @(negedge clk);
        check(done == 1'b1, "R10 first done", done, 1);
        addr = 12'h101; tb_val = 12'h555;
        repeat (WRL - 1) @(negedge clk);
        check(done == 1'b0, "R10 second not yet", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R10 second done", done, 1);
        wr = 1'b0; tb_en = 1'b0;
        do_read(12'h100, 12'hAAA);
        do_read(12'h101, 12'h555);

        // R9: reset during a write clears everything
        do_write(12'h040, 12'h444);
        @(negedge clk);
        wr = 1'b1; addr = 12'h050; tb_val = 12'h555; tb_en = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; wr = 1'b0; tb_en = 1'b0;
        check(done == 1'b0, "R9 no done after reset", done, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 still quiet", done, 0);
        do_read(12'h050, 12'h000);
        do_read(12'h040, 12'h000);  // R1 cleared
        do_read(12'hFFF, 12'h000);  // R1 cleared

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule